// File: doc/BRIEF.md
# Multi-source reset controller

This block produces the core reset of a small processor from four causes: loss of power, a low-active master-clear pin, a watchdog expiry strobe and a supply-low comparator. Each cause sets a hold flop. The hold flop clears only after a power-up delay counter has run a full interval with no cause present. The analog detectors are outside the block and appear here as digital inputs. The delay and the brown-out qualification time are given as counts of the reference clock.

A brown-out counts only when the supply-low input stays high for a minimum number of consecutive clock edges. Shorter dips leave the core running. Any cause that appears while the delay is running starts the delay again, so a supply that drops out during the wait extends the reset. Two cause flags let software tell afterwards what kind of event produced the last reset. On release the block gives a one-cycle load strobe with the start vector, so the program counter starts from that vector.

Top module: `rstgen_multi`

## Requirements
- R1: `core_rst_n` is low in any cycle in which a cause is active. Active causes are `pwr_ok` low, the synchronized master clear, `wdt_expire` high, or a qualified brown-out. A `wdt_expire` pulse pulls `core_rst_n` low in the same cycle, before any clock edge.
- R2: `pwr_ok` low forces `core_rst_n` low at once, with no clock edge needed. It also sets both `flag_to` and `flag_pd` to 1.
- R3: `mclr_n` passes through SYNC_STAGES flops. `core_rst_n` goes low on the SYNC_STAGES-th rising edge after `mclr_n` is first sampled low.
- R4: A brown-out qualifies when `supply_low` is sampled high on BO_CYC consecutive rising edges. `core_rst_n` then goes low on that edge. A run of fewer than BO_CYC high samples leaves `core_rst_n` high.
- R5: `core_rst_n` rises on the PWRT_CYC-th rising edge after the last edge at which a cause was active. A power-up counts as active at edge 0, the last edge before `pwr_ok` goes high.
- R6: A cause that appears while the delay is running restarts the delay from that cause's last active edge. `core_rst_n` stays low over the whole span.
- R7: The cause flags follow these rules:
  - A watchdog expiry with no brown-out clears `flag_to` and leaves `flag_pd` unchanged.
  - A brown-out sets both flags to 1.
  - A master clear alone leaves both flags unchanged.
- R8: `pc_load` is high for exactly one cycle, the first cycle in which `core_rst_n` is high after a reset. `pc_vec` always equals RST_VEC, which is 0 by default.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock that all delay counts are measured in |
| pwr_ok | input | 1 | Power-good from the supply detector; low means power is absent (asynchronous) |
| mclr_n | input | 1 | External master clear, active low, asynchronous |
| wdt_expire | input | 1 | Watchdog expiry strobe, synchronous to clk |
| supply_low | input | 1 | Brown-out comparator output, high while the supply is below threshold |
| core_rst_n | output | 1 | Core reset, active low |
| flag_to | output | 1 | Time-out cause flag, cleared by a watchdog reset |
| flag_pd | output | 1 | Power-down cause flag, set by power-on or brown-out |
| pc_load | output | 1 | One-cycle strobe on release to load the program counter |
| pc_vec | output | PC_W | Start vector for the program counter |

## Verification
Master-clear pulses of one to four cycles separate the synchronizer latency from the width-dependent release point. Watchdog strobes of one to three cycles show that the delay counts from the last active edge and not the first. Supply dips are tried at every length from one sample up to two samples past the qualifying length. Dips below the threshold must leave the core running, and dips at or above it must give a release point that moves with the dip's end. A drop-out in the middle of the delay, a power loss between clock edges and a watchdog reset followed by a master clear show the restart rule, the asynchronous path and which events the cause flags keep or change.

// File: rtl/rstgen_pkg.sv
package rstgen_pkg;

   // Cause flag pair as seen by software.
   typedef struct packed {
      logic to;
      logic pd;
   } rst_cause_t;

   localparam rst_cause_t CAUSE_POWER = '{to: 1'b1, pd: 1'b1};

   // Width helper: at least one bit for a counter reaching value v.
   function automatic int unsigned cnt_width(input int unsigned v);
      return (v < 2) ? 1 : $clog2(v + 1);
   endfunction

endpackage

// File: rtl/rstgen_sync.sv
module rstgen_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("rstgen_sync: STAGES must be at least 2");
   end

   for (genvar i = 0; i < STAGES; i++) begin : g_stg
      logic stg_q;
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg_q <= 1'b0;
            else        stg_q <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg_q <= 1'b0;
            else        stg_q <= g_stg[i-1].stg_q;
         end
      end
   end

   assign q = g_stg[STAGES-1].stg_q;

endmodule

// File: rtl/rstgen_bo_filter.sv
module rstgen_bo_filter
   import rstgen_pkg::*;
#(
   parameter int unsigned BO_CYC = 3200
) (
   input  logic clk,
   input  logic rst_n,
   input  logic supply_low,
   output logic bo_evt
);

   localparam int unsigned BW = cnt_width(BO_CYC);
   localparam logic [BW-1:0] SAT  = BW'(BO_CYC);
   localparam logic [BW-1:0] NEAR = BW'(BO_CYC - 1);

   if (BO_CYC < 1) begin : g_bad_bo
      $error("rstgen_bo_filter: BO_CYC must be at least 1");
   end

   logic [BW-1:0] low_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_run <= '0;
         bo_evt  <= 1'b0;
      end else if (!supply_low) begin
         low_run <= '0;
         bo_evt  <= 1'b0;
      end else begin
         if (low_run != SAT) low_run <= low_run + 1'b1;
         bo_evt <= (low_run >= NEAR);
      end
   end

   // R4
   bo_qualified_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bo_evt) |-> $past(supply_low));

   // R4
   bo_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !supply_low |=> !bo_evt);

endmodule

// File: rtl/rstgen_pwrt.sv
module rstgen_pwrt
   import rstgen_pkg::*;
#(
   parameter int unsigned PWRT_CYC = 2304000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_now,
   output logic hold,
   output logic released
);

   localparam int unsigned CW = cnt_width(PWRT_CYC);
   localparam logic [CW-1:0] LAST = CW'(PWRT_CYC - 1);

   if (PWRT_CYC < 1) begin : g_bad_pwrt
      $error("rstgen_pwrt: PWRT_CYC must be at least 1");
   end

   logic [CW-1:0] wait_cnt;
   logic          hold_d1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold     <= 1'b1;
         wait_cnt <= '0;
      end else if (set_now) begin
         hold     <= 1'b1;
         wait_cnt <= '0;
      end else if (hold) begin
         if (wait_cnt == LAST) hold <= 1'b0;
         else                  wait_cnt <= wait_cnt + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hold_d1 <= 1'b1;
      else        hold_d1 <= hold;
   end

   assign released = hold_d1 & ~hold & ~set_now;

   // R6
   restart_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_now |=> hold);

endmodule

// File: rtl/rstgen_cause.sv
module rstgen_cause
   import rstgen_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wdt_evt,
   input  logic       bo_evt,
   output rst_cause_t cause
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cause <= CAUSE_POWER;
      else if (bo_evt)  cause <= CAUSE_POWER;
      else if (wdt_evt) cause.to <= 1'b0;
   end

   // R7
   wdt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wdt_evt && !bo_evt |=> !cause.to);

   // R7
   bo_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bo_evt |=> cause.to && cause.pd);

   // R7
   keep_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wdt_evt && !bo_evt |=> $stable(cause));

endmodule

// File: rtl/rstgen_multi.sv
module rstgen_multi
   import rstgen_pkg::*;
#(
   parameter int unsigned PC_W        = 13,
   parameter int unsigned RST_VEC     = 0,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned BO_CYC      = 3200,
   parameter int unsigned PWRT_CYC    = 2304000
) (
   input  logic            clk,
   input  logic            pwr_ok,
   input  logic            mclr_n,
   input  logic            wdt_expire,
   input  logic            supply_low,
   output logic            core_rst_n,
   output logic            flag_to,
   output logic            flag_pd,
   output logic            pc_load,
   output logic [PC_W-1:0] pc_vec
);

   if (RST_VEC >= (64'd1 << PC_W)) begin : g_bad_vec
      $error("rstgen_multi: RST_VEC does not fit in PC_W bits");
   end

   logic       mclr_s;
   logic       bo_evt;
   logic       set_now;
   logic       hold;
   rst_cause_t cause;

   rstgen_sync #(.STAGES(SYNC_STAGES)) u_mclr_sync (
      .clk   (clk),
      .rst_n (pwr_ok),
      .d     (~mclr_n),
      .q     (mclr_s)
   );

   rstgen_bo_filter #(.BO_CYC(BO_CYC)) u_bo (
      .clk        (clk),
      .rst_n      (pwr_ok),
      .supply_low (supply_low),
      .bo_evt     (bo_evt)
   );

   assign set_now = mclr_s | wdt_expire | bo_evt;

   rstgen_pwrt #(.PWRT_CYC(PWRT_CYC)) u_pwrt (
      .clk      (clk),
      .rst_n    (pwr_ok),
      .set_now  (set_now),
      .hold     (hold),
      .released (pc_load)
   );

   rstgen_cause u_cause (
      .clk     (clk),
      .rst_n   (pwr_ok),
      .wdt_evt (wdt_expire),
      .bo_evt  (bo_evt),
      .cause   (cause)
   );

   assign core_rst_n = ~(hold | set_now);
   assign flag_to    = cause.to;
   assign flag_pd    = cause.pd;
   assign pc_vec     = PC_W'(RST_VEC);

   // R1
   src_holds_chk: assert property (@(posedge clk) disable iff (!pwr_ok)
      set_now |=> !core_rst_n);

   // R8
   load_on_release_chk: assert property (@(posedge clk) disable iff (!pwr_ok)
      $rose(core_rst_n) |-> pc_load);

   // R8
   load_single_chk: assert property (@(posedge clk) disable iff (!pwr_ok)
      pc_load |=> !pc_load);

endmodule

// File: tb/rstgen_multi_bench.sv
module rstgen_multi_bench;

   localparam int SYNC = 2;
   localparam int BO   = 4;
   localparam int PW   = 10;

   logic        clk = 1'b0;
   logic        pwr_ok, mclr_n, wdt_expire, supply_low;
   logic        core_rst_n, flag_to, flag_pd, pc_load;
   logic [12:0] pc_vec;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #4 clk = ~clk;

   rstgen_multi #(
      .PC_W(13), .RST_VEC(0), .SYNC_STAGES(SYNC), .BO_CYC(BO), .PWRT_CYC(PW)
   ) u_rstgen_multi (
      .clk(clk), .pwr_ok(pwr_ok), .mclr_n(mclr_n), .wdt_expire(wdt_expire),
      .supply_low(supply_low), .core_rst_n(core_rst_n), .flag_to(flag_to),
      .flag_pd(flag_pd), .pc_load(pc_load), .pc_vec(pc_vec)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick;
      @(posedge clk);
      @(negedge clk);
   endtask

   // Edges until core_rst_n is high, counting on from n.
   task automatic wait_release(inout int n);
      while (!core_rst_n && n < 1000) begin
         tick();
         n++;
      end
   endtask

   task automatic settle;
      repeat (3) tick();
   endtask

   initial begin
      int n;
      int first;
      bit bad;
      pwr_ok = 1'b0; mclr_n = 1'b1; wdt_expire = 1'b0; supply_low = 1'b0;
      repeat (3) @(negedge clk);

      // R2: power absent
      chk(core_rst_n == 1'b0, "R2 rst low at power-off", core_rst_n, 0);
      chk(flag_to == 1'b1 && flag_pd == 1'b1, "R2 flags set at power-off",
          {flag_to, flag_pd}, 3);
      // R8: start vector
      chk(pc_vec == 13'd0, "R8 pc_vec", pc_vec, 0);

      // R5: power-up delay
      pwr_ok = 1'b1;
      n = 0;
      wait_release(n);
      chk(n == PW, "R5 power-up release edge", n, PW);
      chk(pc_load == 1'b1, "R8 pc_load at release", pc_load, 1);
      tick();
      chk(pc_load == 1'b0 && core_rst_n == 1'b1, "R8 pc_load single cycle", pc_load, 0);

      // R1 R5 R7: watchdog strobes of several widths
      for (int w = 1; w <= 3; w++) begin
         wdt_expire = 1'b1;
         #1;
         chk(core_rst_n == 1'b0, "R1 wdt asserts same cycle", core_rst_n, 0);
         n = 0;
         while (n < w) begin
            tick();
            n++;
         end
         wdt_expire = 1'b0;
         wait_release(n);
         chk(n == w + PW, "R5 wdt release edge", n, w + PW);
         chk(flag_to == 1'b0 && flag_pd == 1'b1, "R7 wdt clears to keeps pd",
             {flag_to, flag_pd}, 1);
         settle();
      end

      // R3 R5 R7: master clear pulses
      for (int w = 1; w <= 4; w++) begin
         mclr_n = 1'b0;
         n = 0;
         first = -1;
         do begin
            tick();
            n++;
            if (n == w) mclr_n = 1'b1;
            if (!core_rst_n && first < 0) first = n;
         end while (!(core_rst_n && first >= 0) && n < 1000);
         chk(first == SYNC, "R3 mclr assert latency", first, SYNC);
         chk(n == w + SYNC + PW, "R5 mclr release edge", n, w + SYNC + PW);
         chk(flag_to == 1'b0 && flag_pd == 1'b1, "R7 mclr keeps flags",
             {flag_to, flag_pd}, 1);
         settle();
      end

      // R4: dips shorter than qualification time are ignored
      for (int d = 1; d < BO; d++) begin
         bad = 1'b0;
         supply_low = 1'b1;
         for (int k = 1; k <= d + 3; k++) begin
            tick();
            if (k == d) supply_low = 1'b0;
            if (!core_rst_n) bad = 1'b1;
         end
         chk(!bad, "R4 short dip ignored", bad, 0);
         chk(flag_to == 1'b0, "R4 short dip keeps flags", flag_to, 0);
      end

      // R4 R5 R7: qualified brown-out of several lengths
      for (int h = BO; h <= BO + 2; h++) begin
         supply_low = 1'b1;
         n = 0;
         first = -1;
         do begin
            tick();
            n++;
            if (n == h) supply_low = 1'b0;
            if (!core_rst_n && first < 0) first = n;
         end while (!(core_rst_n && first >= 0) && n < 1000);
         chk(first == BO, "R4 brown-out assert edge", first, BO);
         chk(n == h + 1 + PW, "R5 brown-out release edge", n, h + 1 + PW);
         chk(flag_to == 1'b1 && flag_pd == 1'b1, "R7 brown-out sets flags",
             {flag_to, flag_pd}, 3);
         settle();
      end

      // R6: supply drops out again during the delay
      bad = 1'b0;
      n = 0;
      first = -1;
      supply_low = 1'b1;
      do begin
         tick();
         n++;
         if (n == BO) supply_low = 1'b0;
         if (n == BO + 2) supply_low = 1'b1;
         if (n == 2 * BO + 2) supply_low = 1'b0;
         if (!core_rst_n && first < 0) first = n;
         if (first >= 0 && core_rst_n && n < 2 * BO + 3 + PW) bad = 1'b1;
      end while (!(core_rst_n && first >= 0) && n < 1000);
      chk(n == 2 * BO + 3 + PW, "R6 restart release edge", n, 2 * BO + 3 + PW);
      chk(!bad, "R6 no early release", bad, 0);
      settle();

      // R2: power lost between edges
      wdt_expire = 1'b1;
      tick();
      wdt_expire = 1'b0;
      n = 1;
      wait_release(n);
      settle();
      chk(flag_to == 1'b0, "R7 wdt before power loss", flag_to, 0);
      #2;
      pwr_ok = 1'b0;
      #1;
      chk(core_rst_n == 1'b0, "R2 async power loss", core_rst_n, 0);
      chk(flag_to == 1'b1 && flag_pd == 1'b1, "R2 flags after power loss",
          {flag_to, flag_pd}, 3);
      @(negedge clk);
      pwr_ok = 1'b1;
      n = 0;
      wait_release(n);
      chk(n == PW, "R5 release after power loss", n, PW);

      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++;
         fails++;
         $display("FAIL watchdog run did not complete actual=0 expected=1");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule